// File: doc/BRIEF.md
# Dual Capture/Compare Timer Channels

Two timer channels share one free-running up-counter that wraps at a programmable modulus. Each channel is configured through a four-bit field: two mode bits pick capture, compare, or buffered compare, and two edge/level bits pick which pin edge is captured or what a compare match does to the pin. When the edge/level field is zero, the pin is handed back to general-purpose port data, and the mode-A bit presets the level that the compare logic will start from.

Setting mode-B on channel 0 joins the two channels into one buffered compare/PWM output on pin 0. The compare target then alternates between the two value registers, and the next target is taken only at a match. In this mode channel 1's control register is locked and pin 1 is driven from port data. Mode fields are staged: a written field takes effect only while the counter is both halted and held at zero, so a running waveform is never disturbed by a reconfiguration.

Top module: `cc_pair_timer`

## Requirements
- R1: After reset the counter runs from 0, the modulus is 0xFFFF and every mode field is 0. While running, the counter counts up by one per clock and goes to 0 on the clock after it reaches or exceeds the modulus. Halt freezes it, and hold forces it to 0.
- R2: With edge/level bits 00, the pin copies portOut/portOe, and the channel's internal level is preset to 0 when mode-A is 1 and to 1 when mode-A is 0. A later compare mode starts from that level.
- R3: With mode-B=0 and mode-A=0, the channel captures on edges of the pin after a two-flop synchronizer: edge bits 01 select rising, 10 falling, 11 both. A capture copies the counter into the value register and sets the flag. The pin is an input (pinOe=0).
- R4: With mode-A=1 and edge bits non-zero, the pin is driven from the channel level, and a running-counter match of the value register toggles it (01), clears it (10) or sets it (11). Every match also sets the flag.
- R5: In compare mode with edge bits 00, a match sets only the flag, and the pin stays on port data.
- R6: Channel 0 mode-B=1 selects buffered compare on pin 0 with the same action encoding. The target starts at value 0, swaps between value 0 and value 1 at every match, and returns to value 0 when the mode is applied. While active, writes to channel 1's control are ignored, it reads as 0, channel 1 sets no flag, and pin 1 copies port data.
- R7: A flag clears only when its control register was read while the flag was 1 and then written with bit 7 = 0. A new event in the same cycle wins over the clear.
- R8: With clear (10) or set (11) actions, a counter wrap drives the pin to its start-of-period level: 1 for clear, 0 for set. This wins over a simultaneous match, so a target equal to the modulus gives a constant 100 % duty.
- R9: Written mode fields are applied only on clocks where halt and hold are both 1. Otherwise the active configuration is unchanged.
- R10: Register map, addressed on busAddr:
  - 0: control, with bit 0 halt and bit 1 hold.
  - 1: counter, read only.
  - 2: modulus.
  - 3: channel 0 control, with bits [1:0] edge/level, bit 2 mode-A, bit 3 mode-B and bit 7 the flag (read).
  - 4: channel 0 value.
  - 5: channel 1 control, laid out as address 3.
  - 6: channel 1 value.
  
  Reads are combinational, and the control registers read back the written fields.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| busAddr | input | 3 | Register address |
| busWrEn | input | 1 | Register write strobe |
| busRdEn | input | 1 | Register read strobe (arms flag clearing) |
| busWrData | input | 16 | Write data |
| busRdData | output | 16 | Read data |
| pinIn | input | 2 | Sampled level of each channel pin |
| portOut | input | 2 | Fallback port output data |
| portOe | input | 2 | Fallback port output enable |
| pinOut | output | 2 | Pin output level |
| pinOe | output | 2 | Pin output enable |
| chanFlag | output | 2 | Channel event flag |

## Verification
A wrong counter or a stale active mode shows as a pin edge in the wrong cycle, or a flag rising one period off. Both are visible on pinOut, pinOe and chanFlag within one counter period of the fault. A bad buffered-target pointer moves every second edge of pin 0. A broken flag-clear handshake leaves chanFlag high on the clock after the clearing write. Because the reference model is compared on every clock, each such fault is reported in the first cycle it reaches a port.

// File: rtl/cc_pair_pkg.sv
package cc_pair_pkg;
  localparam int NCH = 2;

  typedef struct packed {
    logic       modeB;
    logic       modeA;
    logic [1:0] edgeSel;
  } chanCfg_t;

  typedef struct packed {
    logic           tick;
    logic           wrap;
    logic           apply;
    logic           buffered;
    logic [NCH-1:0] valWr;
    logic [NCH-1:0] flagClr;
  } strobe_t;
endpackage

// File: rtl/cc_pair_ctrl.sv
module cc_pair_ctrl
  import cc_pair_pkg::*;
#(
  parameter int W  = 16,
  parameter int AW = 3
) (
  input  logic                    clk,
  input  logic                    rstN,
  input  logic [AW-1:0]           busAddr,
  input  logic                    busWrEn,
  input  logic                    busRdEn,
  input  logic [W-1:0]            busWrData,
  output logic [W-1:0]            busRdData,
  input  logic [NCH-1:0][W-1:0]   valQ,
  input  logic [NCH-1:0]          flagQ,
  output strobe_t                 stb,
  output chanCfg_t [NCH-1:0]      actCfg,
  output logic [W-1:0]            count
);
  localparam logic [AW-1:0] ADDR_CTL  = AW'(0);
  localparam logic [AW-1:0] ADDR_CNT  = AW'(1);
  localparam logic [AW-1:0] ADDR_MOD  = AW'(2);
  localparam logic [AW-1:0] ADDR_C0   = AW'(3);
  localparam logic [AW-1:0] ADDR_V0   = AW'(4);
  localparam logic [AW-1:0] ADDR_C1   = AW'(5);
  localparam logic [AW-1:0] ADDR_V1   = AW'(6);
  localparam int FLAG_BIT = 7;

  logic halt, hold;
  logic [W-1:0] modulus;
  chanCfg_t [NCH-1:0] pendCfg;
  logic [NCH-1:0] armed, rdHit;
  logic ch1Open;

  assign ch1Open = !actCfg[0].modeB;

  always_comb begin
    stb.tick     = !halt && !hold;
    stb.wrap     = stb.tick && (count >= modulus);
    stb.apply    = halt && hold;
    stb.buffered = actCfg[0].modeB;
    stb.valWr[0] = busWrEn && busAddr == ADDR_V0;
    stb.valWr[1] = busWrEn && busAddr == ADDR_V1;
    rdHit[0]     = busRdEn && busAddr == ADDR_C0;
    rdHit[1]     = busRdEn && busAddr == ADDR_C1 && ch1Open;
    stb.flagClr[0] = busWrEn && busAddr == ADDR_C0 && !busWrData[FLAG_BIT] && armed[0];
    stb.flagClr[1] = busWrEn && busAddr == ADDR_C1 && !busWrData[FLAG_BIT] && armed[1] && ch1Open;
  end

  always_comb begin
    busRdData = '0;
    case (busAddr)
      ADDR_CTL: busRdData = W'({hold, halt});
      ADDR_CNT: busRdData = count;
      ADDR_MOD: busRdData = modulus;
      ADDR_C0:  begin busRdData[3:0] = pendCfg[0]; busRdData[FLAG_BIT] = flagQ[0]; end
      ADDR_V0:  busRdData = valQ[0];
      ADDR_C1:  if (ch1Open) begin busRdData[3:0] = pendCfg[1]; busRdData[FLAG_BIT] = flagQ[1]; end
      ADDR_V1:  busRdData = valQ[1];
      default:  busRdData = '0;
    endcase
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      halt    <= 1'b0;
      hold    <= 1'b0;
      modulus <= '1;
      count   <= '0;
      pendCfg <= '0;
      actCfg  <= '0;
      armed   <= '0;
    end else begin
      if (hold) count <= '0;
      else if (!halt) count <= (count >= modulus) ? '0 : count + 1'b1;
      if (stb.apply) actCfg <= pendCfg;
      if (busWrEn) begin
        case (busAddr)
          ADDR_CTL: {hold, halt} <= busWrData[1:0];
          ADDR_MOD: modulus <= busWrData;
          ADDR_C0:  pendCfg[0] <= busWrData[3:0];
          ADDR_C1:  if (ch1Open) pendCfg[1] <= busWrData[3:0];
          default: ;
        endcase
      end
      for (int c = 0; c < NCH; c++) begin
        if (stb.flagClr[c]) armed[c] <= 1'b0;
        else if (rdHit[c] && flagQ[c]) armed[c] <= 1'b1;
      end
    end
  end

  assert_mode_hold_R9: assert property (@(posedge clk) disable iff (!rstN)
    !(halt && hold) |=> $stable(actCfg));
  assert_ch1_locked_R6: assert property (@(posedge clk) disable iff (!rstN)
    (busWrEn && busAddr == ADDR_C1 && actCfg[0].modeB) |=> $stable(pendCfg[1]));
  assert_wrap_zero_R1: assert property (@(posedge clk) disable iff (!rstN)
    stb.wrap |=> (count == '0));
endmodule

// File: rtl/cc_pair_dp.sv
module cc_pair_dp
  import cc_pair_pkg::*;
#(
  parameter int W = 16
) (
  input  logic                  clk,
  input  logic                  rstN,
  input  strobe_t               stb,
  input  chanCfg_t [NCH-1:0]    actCfg,
  input  logic [W-1:0]          count,
  input  logic [W-1:0]          wrData,
  input  logic [NCH-1:0]        pinIn,
  input  logic [NCH-1:0]        portOut,
  input  logic [NCH-1:0]        portOe,
  output logic [NCH-1:0][W-1:0] valQ,
  output logic [NCH-1:0]        flagQ,
  output logic [NCH-1:0]        pinOut,
  output logic [NCH-1:0]        pinOe
);
  logic [NCH-1:0] matchEvt;
  logic bufSel;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) bufSel <= 1'b0;
    else if (stb.apply) bufSel <= 1'b0;
    else if (stb.buffered && matchEvt[0]) bufSel <= !bufSel;
  end

  for (genvar i = 0; i < NCH; i++) begin : g_ch
    logic syncA, syncB, prevB, rise, fall;
    logic active, modeBEff, isCap, isCmp, capEvt, level, flagR;
    logic [W-1:0] valR, target;

    assign active   = (i == 0) || !stb.buffered;
    assign modeBEff = (i == 0) ? actCfg[i].modeB : 1'b0;
    assign isCap    = active && !actCfg[i].modeA && !modeBEff;
    assign isCmp    = active && (actCfg[i].modeA || modeBEff);
    assign rise     = syncB && !prevB;
    assign fall     = !syncB && prevB;
    assign capEvt   = isCap && ((actCfg[i].edgeSel[0] && rise) || (actCfg[i].edgeSel[1] && fall));
    if (i == 0) begin : g_buf
      assign target = (stb.buffered && bufSel) ? valQ[1] : valR;
    end else begin : g_plain
      assign target = valR;
    end
    assign matchEvt[i] = isCmp && stb.tick && (count == target);

    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN) begin
        syncA <= 1'b0; syncB <= 1'b0; prevB <= 1'b0;
        valR <= '0; flagR <= 1'b0; level <= 1'b1;
      end else begin
        syncA <= pinIn[i];
        syncB <= syncA;
        prevB <= syncB;
        if (capEvt) valR <= count;
        else if (stb.valWr[i]) valR <= wrData;
        if (capEvt || matchEvt[i]) flagR <= 1'b1;
        else if (stb.flagClr[i]) flagR <= 1'b0;
        if (actCfg[i].edgeSel == 2'b00) level <= !actCfg[i].modeA;
        else if (isCmp) begin
          if (stb.wrap && actCfg[i].edgeSel[1]) level <= !actCfg[i].edgeSel[0];
          else if (matchEvt[i]) begin
            case (actCfg[i].edgeSel)
              2'b01:   level <= !level;
              2'b10:   level <= 1'b0;
              default: level <= 1'b1;
            endcase
          end
        end
      end
    end

    always_comb begin
      if (isCmp && actCfg[i].edgeSel != 2'b00) begin
        pinOe[i] = 1'b1; pinOut[i] = level;
      end else if (isCap && actCfg[i].edgeSel != 2'b00) begin
        pinOe[i] = 1'b0; pinOut[i] = 1'b0;
      end else begin
        pinOe[i] = portOe[i]; pinOut[i] = portOut[i];
      end
    end

    assign valQ[i]  = valR;
    assign flagQ[i] = flagR;

    assert_capture_latch_R3: assert property (@(posedge clk) disable iff (!rstN)
      capEvt |=> (valQ[i] == $past(count) && flagQ[i]));
  end

  assert_ch1_port_R6: assert property (@(posedge clk) disable iff (!rstN)
    stb.buffered |-> (pinOe[1] == portOe[1] && pinOut[1] == portOut[1] && !matchEvt[1]));
endmodule

// File: rtl/cc_pair_timer.sv
module cc_pair_timer
  import cc_pair_pkg::*;
#(
  parameter int W  = 16,
  parameter int AW = 3
) (
  input  logic          clk,
  input  logic          rstN,
  input  logic [AW-1:0] busAddr,
  input  logic          busWrEn,
  input  logic          busRdEn,
  input  logic [W-1:0]  busWrData,
  output logic [W-1:0]  busRdData,
  input  logic [1:0]    pinIn,
  input  logic [1:0]    portOut,
  input  logic [1:0]    portOe,
  output logic [1:0]    pinOut,
  output logic [1:0]    pinOe,
  output logic [1:0]    chanFlag
);
  strobe_t stb;
  chanCfg_t [NCH-1:0] actCfg;
  logic [W-1:0] count;
  logic [NCH-1:0][W-1:0] valQ;

  cc_pair_ctrl #(.W(W), .AW(AW)) u_ctrl (
    .clk(clk), .rstN(rstN), .busAddr(busAddr), .busWrEn(busWrEn), .busRdEn(busRdEn),
    .busWrData(busWrData), .busRdData(busRdData), .valQ(valQ), .flagQ(chanFlag),
    .stb(stb), .actCfg(actCfg), .count(count));

  cc_pair_dp #(.W(W)) u_dp (
    .clk(clk), .rstN(rstN), .stb(stb), .actCfg(actCfg), .count(count),
    .wrData(busWrData), .pinIn(pinIn), .portOut(portOut), .portOe(portOe),
    .valQ(valQ), .flagQ(chanFlag), .pinOut(pinOut), .pinOe(pinOe));
endmodule

// File: tb/cc_pair_timer_test.sv
module cc_pair_timer_test;
  localparam int CLK_PERIOD = 10;

  logic clk = 0, rstN = 0;
  logic [2:0] busAddr = 0;
  logic busWrEn = 0, busRdEn = 0;
  logic [15:0] busWrData = 0, busRdData;
  logic [1:0] pinIn = 0, portOut = 0, portOe = 0, pinOut, pinOe, chanFlag;

  int nChecks = 0, nFails = 0;
  string curReq = "R1";

  cc_pair_timer uut (.clk(clk), .rstN(rstN), .busAddr(busAddr), .busWrEn(busWrEn),
    .busRdEn(busRdEn), .busWrData(busWrData), .busRdData(busRdData), .pinIn(pinIn),
    .portOut(portOut), .portOe(portOe), .pinOut(pinOut), .pinOe(pinOe), .chanFlag(chanFlag));

  always #(CLK_PERIOD/2) clk = !clk;

  // behavioural reference model
  int mCnt, mMod, mVal[2];
  bit mHalt, mHold, mSel;
  bit [3:0] mPend[2], mAct[2];
  bit mFlag[2], mArm[2], mLvl[2], h1[2], h2[2], h3[2];

  function automatic bit mActive(int c); return c == 0 || !mAct[0][3]; endfunction
  function automatic bit mIsCmp(int c);
    return mActive(c) && (mAct[c][2] || (c == 0 && mAct[c][3]));
  endfunction
  function automatic bit mIsCap(int c);
    return mActive(c) && !mAct[c][2] && !(c == 0 && mAct[c][3]);
  endfunction

  always @(posedge clk or negedge rstN) begin
    bit tick, wrap, apply, bufd, open;
    bit capE[2], mat[2], clr[2];
    int tgt;
    if (!rstN) begin
      mCnt = 0; mMod = 'hFFFF; mHalt = 0; mHold = 0; mSel = 0;
      for (int c = 0; c < 2; c++) begin
        mVal[c] = 0; mPend[c] = 0; mAct[c] = 0; mFlag[c] = 0; mArm[c] = 0;
        mLvl[c] = 1; h1[c] = 0; h2[c] = 0; h3[c] = 0;
      end
    end else begin
      tick = !mHalt && !mHold; wrap = tick && mCnt >= mMod; apply = mHalt && mHold;
      bufd = mAct[0][3]; open = !bufd;
      for (int c = 0; c < 2; c++) begin
        capE[c] = mIsCap(c) && ((mAct[c][0] && h2[c] && !h3[c]) || (mAct[c][1] && !h2[c] && h3[c]));
        tgt = (c == 0 && bufd && mSel) ? mVal[1] : mVal[c];
        mat[c] = mIsCmp(c) && tick && mCnt == tgt;
        clr[c] = busWrEn && busAddr == (c ? 5 : 3) && !busWrData[7] && mArm[c] && (c == 0 || open);
      end
      for (int c = 0; c < 2; c++) begin
        if (mAct[c][1:0] == 0) mLvl[c] = !mAct[c][2];
        else if (mIsCmp(c)) begin
          if (wrap && mAct[c][1]) mLvl[c] = !mAct[c][0];
          else if (mat[c]) mLvl[c] = (mAct[c][1:0] == 1) ? !mLvl[c] : mAct[c][0];
        end
        if (clr[c]) mArm[c] = 0;
        else if (busRdEn && busAddr == (c ? 5 : 3) && (c == 0 || open) && mFlag[c]) mArm[c] = 1;
        if (capE[c] || mat[c]) mFlag[c] = 1; else if (clr[c]) mFlag[c] = 0;
        if (capE[c]) mVal[c] = mCnt;
        else if (busWrEn && busAddr == (c ? 6 : 4)) mVal[c] = busWrData;
        h3[c] = h2[c]; h2[c] = h1[c]; h1[c] = pinIn[c];
      end
      if (apply) mSel = 0; else if (bufd && mat[0]) mSel = !mSel;
      if (mHold) mCnt = 0; else if (!mHalt) mCnt = (mCnt >= mMod) ? 0 : mCnt + 1;
      if (apply) begin mAct[0] = mPend[0]; mAct[1] = mPend[1]; end
      if (busWrEn) begin
        if (busAddr == 0) begin mHalt = busWrData[0]; mHold = busWrData[1]; end
        if (busAddr == 2) mMod = busWrData;
        if (busAddr == 3) mPend[0] = busWrData[3:0];
        if (busAddr == 5 && open) mPend[1] = busWrData[3:0];
      end
    end
  end

  function automatic int mRead(int a);
    case (a)
      0: return {mHold, mHalt};
      1: return mCnt;
      2: return mMod;
      3: return (int'(mFlag[0]) << 7) | mPend[0];
      4: return mVal[0];
      5: return mAct[0][3] ? 0 : ((int'(mFlag[1]) << 7) | mPend[1]);
      6: return mVal[1];
      default: return 0;
    endcase
  endfunction

  task automatic chk(bit ok, string req, int act, int exp);
    nChecks++;
    if (!ok) begin
      nFails++;
      $display("FAIL %s actual=%0h expected=%0h at %0t", req, act, exp, $time);
    end
  endtask

  // per-clock comparison of pins and flags
  always @(negedge clk) if (rstN) begin
    for (int c = 0; c < 2; c++) begin
      bit eo, ev;
      if (mIsCmp(c) && mAct[c][1:0] != 0) begin eo = 1; ev = mLvl[c]; end
      else if (mIsCap(c) && mAct[c][1:0] != 0) begin eo = 0; ev = 0; end
      else begin eo = portOe[c]; ev = portOut[c]; end
      chk(pinOe[c] == eo && pinOut[c] == ev && chanFlag[c] == mFlag[c], curReq,
          {pinOe[c], pinOut[c], chanFlag[c]}, {eo, ev, mFlag[c]});
    end
  end

  task automatic wr(int a, int d);
    @(negedge clk); #2; busAddr = 3'(a); busWrData = 16'(d); busWrEn = 1;
    @(negedge clk); #2; busWrEn = 0;
  endtask

  task automatic rd(int a, string req);
    @(negedge clk); #2; busAddr = 3'(a); busRdEn = 1; #1;
    chk(busRdData == 16'(mRead(a)), req, busRdData, mRead(a));
    @(negedge clk); #2; busRdEn = 0;
  endtask

  task automatic rdLit(int a, int exp, string req);
    @(negedge clk); #2; busAddr = 3'(a); #1;
    chk(busRdData == 16'(exp), req, busRdData, exp);
  endtask

  task automatic idle(int n); repeat (n) @(negedge clk); endtask

  initial begin
    repeat (100000) @(posedge clk);
    chk(0, "watchdog", 0, 1);
    $display("%0d/%0d checks passed", nChecks - nFails, nChecks);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1;
    // R1 reset state
    rdLit(2, 'hFFFF, "R1");
    rdLit(3, 0, "R1");
    rd(1, "R1");
    // R3 capture: ch0 rising, ch1 both edges
    wr(0, 3);
    rdLit(0, 3, "R10");
    wr(2, 9); wr(3, 'h01); wr(5, 'h03); wr(0, 0);
    curReq = "R3";
    for (int k = 0; k < 6; k++) begin idle(4); @(negedge clk); #2; pinIn = ~pinIn; end
    idle(5);
    rd(4, "R3"); rd(6, "R3"); rd(1, "R1");
    // R7 flag clear needs read then write 0
    curReq = "R7";
    wr(3, 'h01); idle(2);
    rd(3, "R7"); wr(3, 'h01); idle(2);
    rd(5, "R7"); wr(5, 'h03); idle(2);
    // R9 mode write while running is staged only
    curReq = "R9";
    wr(3, 'h05); idle(12);
    rd(3, "R10");
    // R4/R8 compare: ch0 toggle at 3, ch1 clear at 5, set at wrap
    wr(0, 3); wr(4, 3); wr(5, 'h06); wr(6, 5); wr(0, 0);
    curReq = "R4"; idle(40);
    curReq = "R8"; idle(10);
    // R2/R5 port control, compare flag only
    curReq = "R5";
    wr(0, 3); portOut = 2'b01; portOe = 2'b11; wr(3, 'h04); wr(0, 0);
    idle(25); portOut = 2'b10; idle(5);
    // R2 preset low then set-on-compare
    curReq = "R2";
    wr(0, 3); wr(3, 'h07); wr(0, 0); idle(25);
    // R8 100 % duty: preset high, clear action, target = modulus
    curReq = "R8";
    wr(0, 3); wr(3, 'h00); idle(2); wr(3, 'h06); wr(4, 9); wr(0, 0); idle(30);
    // R6 buffered compare
    curReq = "R6";
    wr(0, 3); wr(3, 'h09); wr(4, 2); wr(6, 6); wr(0, 0); idle(3);
    wr(5, 'h07);
    rdLit(5, 0, "R6");
    idle(25); wr(4, 4); idle(35);
    rd(3, "R10"); rd(6, "R10"); rd(2, "R10");
    $display("%0d/%0d checks passed", nChecks - nFails, nChecks);
    $finish;
  end
endmodule